// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block turns single bit-level commands into the clock and data waveforms of an I2C master. It runs from the peripheral clock. The caller programs five timing fields:
- a low divisor and a high divisor;
- a count that stretches the setup and hold time around a START;
- a count that stretches the setup time before a STOP;
- an update step that places data changes inside the clock-low phase.

The caller then issues one command at a time: START (which also serves as a repeated START), write one bit, read one bit, or STOP. The two outputs are open-drain pull enables. A 1 pulls the wire low and a 0 releases it.

Timing is built from two units, measured in peripheral cycles: l = low divisor + 1 and h = high divisor + 1. A clock-low phase lasts eight low units. A clock-high phase lasts eight high units. START and STOP timing uses whole multiples of the high unit. SDA changes a programmable number of low units after the clock-low phase begins. This splits the low phase into a hold part and a setup part.

The timing fields are captured when a command is accepted, so they may change between commands. A byte engine above this block handles framing, acknowledge, arbitration and the register map.

Top module: `i2c_bit_sequencer`

## Requirements
- R1: After reset, scl_pull and sda_pull are 0 (both lines released) and done is 1.
- R2: A command is accepted on a rising clock edge where cmd_valid and done are both 1. cmd_op encoding: 0 = START, 1 = WRITE, 2 = READ, 3 = STOP. For WRITE and READ (SCL held low), the sequence is:
  - SCL stays pulled for 8*l cycles after acceptance.
  - SCL is then released for 8*h cycles.
  - SCL is pulled again, and done returns to 1 on that same edge.
- R3: s = clamped step + 1. In every command that has a low phase, sda_pull takes its new value l*s+1 cycles after acceptance. That leaves (8-s)*l-1 cycles of setup before SCL is released. The new values are:
  - WRITE: the inverse of cmd_bit (bit 1 releases SDA).
  - READ and repeated START: released.
  - STOP: pulled.
- R4: An update step above 5 is treated as 5, so s lies between 1 and 6.
- R5: START with SCL released (bus idle), where u = start count + 1:
  - sda_pull rises 8*h*u+1 cycles after acceptance.
  - SCL is pulled 8*h*(u+1)-1 cycles after that, and done returns to 1 on that edge.
- R6: START with SCL held low (repeated START) runs the R2 low phase with SDA released per R3. It then releases SCL and continues with the R5 timing, counted from the SCL release.
- R7: STOP with SCL held low runs the low phase with SDA pulled per R3. It then releases SCL. With p = stop count + 1, it releases SDA 8*h*p+1 cycles after the SCL release, and done returns to 1 on that edge.
- R8: READ captures sda_in 4*h cycles after SCL is released. rd_bit holds that value until the next READ captures.
- R9: While done is 0, cmd_valid is ignored and the running waveform continues unchanged.
- R10: WRITE, READ or STOP issued while SCL is released leaves both lines released and done at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when done is 1 |
| cmd_op | input | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_bit | input | 1 | Bit for WRITE |
| div_lo | input | DIV_W | Low divisor, l = div_lo + 1 |
| div_hi | input | DIV_W | High divisor, h = div_hi + 1 |
| start_cnt | input | CNT_W | START setup/hold multiplier, u = start_cnt + 1 |
| stop_cnt | input | CNT_W | STOP setup multiplier, p = stop_cnt + 1 |
| upd_step | input | 3 | SDA update step, clamped to 5 |
| sda_in | input | 1 | Sensed SDA wire level |
| done | output | 1 | High when idle and ready for a command |
| rd_bit | output | 1 | Last bit captured by READ |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume three things about the inputs:
- cmd_op and the timing fields are meaningful only in the cycle a command is accepted.
- sda_in is stable through the high phase of a READ.
- The divisors and counts stay small enough that no phase limit overflows the counter width.

The stimulus draws the divisors from 0 to 3 and the counts from 0 to 2, holds the external SDA level constant for a whole command, and injects cmd_valid pulses with random codes only while done is low. Directed runs add the worked 5/3-unit timing and the minimum divisors with the step at its largest and out-of-range values.

// File: rtl/i2cbt_pkg.sv
package i2cbt_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bit_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH,
        PH_SETUP,
        PH_HOLD,
        PH_STOP_SU
    } phase_e;

endpackage

// File: rtl/i2cbt_cfg_hold.sv
module i2cbt_cfg_hold #(
    parameter int DIV_W    = 8,
    parameter int CNT_W    = 4,
    parameter int STEP_W   = 3,
    parameter int MAX_STEP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DIV_W-1:0]  div_lo,
    input  logic [DIV_W-1:0]  div_hi,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic [CNT_W-1:0]  stop_cnt,
    input  logic [STEP_W-1:0] upd_step,
    output logic [DIV_W:0]    lu_q,
    output logic [DIV_W:0]    hu_q,
    output logic [CNT_W:0]    uu_q,
    output logic [CNT_W:0]    pu_q,
    output logic [STEP_W-1:0] su_q
);
    localparam logic [STEP_W-1:0] STEP_CAP = STEP_W'(MAX_STEP);
    localparam logic [STEP_W-1:0] S_TOP    = STEP_W'(MAX_STEP + 1);

    typedef struct packed {
        logic [DIV_W:0]    l;
        logic [DIV_W:0]    h;
        logic [CNT_W:0]    u;
        logic [CNT_W:0]    p;
        logic [STEP_W-1:0] s;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [STEP_W-1:0] step_c;

    always_comb begin
        cfg_d  = cfg_q;
        step_c = (upd_step > STEP_CAP) ? STEP_CAP : upd_step;
        if (load) begin
            cfg_d.l = {1'b0, div_lo} + 1'b1;
            cfg_d.h = {1'b0, div_hi} + 1'b1;
            cfg_d.u = {1'b0, start_cnt} + 1'b1;
            cfg_d.p = {1'b0, stop_cnt} + 1'b1;
            cfg_d.s = step_c + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{l: 1, h: 1, u: 1, p: 1, s: 1};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lu_q = cfg_q.l;
    assign hu_q = cfg_q.h;
    assign uu_q = cfg_q.u;
    assign pu_q = cfg_q.p;
    assign su_q = cfg_q.s;

    // R4: the stored step is never zero and never beyond the cap
    p_step_clamped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (su_q != '0 && su_q <= S_TOP));

    // R2: a unit is never zero
    p_units_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lu_q != '0 && hu_q != '0 && uu_q != '0 && pu_q != '0));

endmodule

// File: rtl/i2cbt_limits.sv
module i2cbt_limits #(
    parameter int DIV_W  = 8,
    parameter int CNT_W  = 4,
    parameter int STEP_W = 3,
    parameter int TW     = DIV_W + CNT_W + 5
) (
    input  logic [DIV_W:0]    lu,
    input  logic [DIV_W:0]    hu,
    input  logic [CNT_W:0]    uu,
    input  logic [CNT_W:0]    pu,
    input  logic [STEP_W-1:0] su,
    output logic [TW-1:0]     upd_pt,
    output logic [TW-1:0]     low_last,
    output logic [TW-1:0]     half_last,
    output logic [TW-1:0]     high_last,
    output logic [TW-1:0]     su_start_pt,
    output logic [TW-1:0]     hold_last,
    output logic [TW-1:0]     su_stop_pt
);
    logic [TW-1:0] l_w, h_w, h8, u_w, p_w;

    always_comb begin
        l_w         = TW'(lu);
        h_w         = TW'(hu);
        u_w         = TW'(uu);
        p_w         = TW'(pu);
        h8          = h_w << 3;
        upd_pt      = l_w * TW'(su);
        low_last    = (l_w << 3) - 1'b1;
        half_last   = (h_w << 2) - 1'b1;
        high_last   = h8 - 1'b1;
        su_start_pt = h8 * u_w;
        hold_last   = h8 * (u_w + 1'b1) - TW'(2);
        su_stop_pt  = h8 * p_w;
    end

endmodule

// File: rtl/i2cbt_counter.sv
module i2cbt_counter #(
    parameter int TW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [TW-1:0] cnt_q
);
    logic [TW-1:0] cnt_d;

    always_comb begin
        cnt_d = clr ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R2: phase limits always end a phase before the counter saturates
    p_count_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (cnt_q != '1));

endmodule

// File: rtl/i2c_bit_sequencer.sv
module i2c_bit_sequencer
    import i2cbt_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int CNT_W    = 4,
    parameter int MAX_STEP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_bit,
    input  logic [DIV_W-1:0] div_lo,
    input  logic [DIV_W-1:0] div_hi,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic [CNT_W-1:0] stop_cnt,
    input  logic [2:0]       upd_step,
    input  logic             sda_in,
    output logic             done,
    output logic             rd_bit,
    output logic             scl_pull,
    output logic             sda_pull
);
    localparam int STEP_W = 3;
    localparam int TW     = DIV_W + CNT_W + 5;

    typedef struct packed {
        phase_e  ph;
        bit_op_e op;
        logic    scl;
        logic    sda;
        logic    tgt;
        logic    rd;
    } seq_t;

    seq_t seq_d, seq_q;
    logic cnt_clr, accept;

    logic [DIV_W:0]    lu, hu;
    logic [CNT_W:0]    uu, pu;
    logic [STEP_W-1:0] su;
    logic [TW-1:0]     cnt_q;
    logic [TW-1:0]     upd_pt, low_last, half_last, high_last;
    logic [TW-1:0]     su_start_pt, hold_last, su_stop_pt;

    assign accept = cmd_valid && (seq_q.ph == PH_IDLE);

    i2cbt_cfg_hold #(
        .DIV_W(DIV_W), .CNT_W(CNT_W), .STEP_W(STEP_W), .MAX_STEP(MAX_STEP)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .div_lo(div_lo), .div_hi(div_hi),
        .start_cnt(start_cnt), .stop_cnt(stop_cnt), .upd_step(upd_step),
        .lu_q(lu), .hu_q(hu), .uu_q(uu), .pu_q(pu), .su_q(su)
    );

    i2cbt_limits #(
        .DIV_W(DIV_W), .CNT_W(CNT_W), .STEP_W(STEP_W), .TW(TW)
    ) u_lim (
        .lu(lu), .hu(hu), .uu(uu), .pu(pu), .su(su),
        .upd_pt(upd_pt), .low_last(low_last), .half_last(half_last),
        .high_last(high_last), .su_start_pt(su_start_pt),
        .hold_last(hold_last), .su_stop_pt(su_stop_pt)
    );

    i2cbt_counter #(.TW(TW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .cnt_q(cnt_q)
    );

    always_comb begin
        seq_d   = seq_q;
        cnt_clr = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: begin
                cnt_clr = 1'b1;
                if (cmd_valid) begin
                    seq_d.op = bit_op_e'(cmd_op);
                    unique case (bit_op_e'(cmd_op))
                        OP_START: begin
                            seq_d.tgt = 1'b0;
                            seq_d.ph  = seq_q.scl ? PH_LOW : PH_SETUP;
                        end
                        OP_WRITE: begin
                            seq_d.tgt = ~cmd_bit;
                            if (seq_q.scl) seq_d.ph = PH_LOW;
                        end
                        OP_READ: begin
                            seq_d.tgt = 1'b0;
                            if (seq_q.scl) seq_d.ph = PH_LOW;
                        end
                        OP_STOP: begin
                            seq_d.tgt = 1'b1;
                            if (seq_q.scl) seq_d.ph = PH_LOW;
                        end
                        default: seq_d.ph = PH_IDLE;
                    endcase
                end
            end
            PH_LOW: begin
                if (cnt_q == upd_pt) begin
                    seq_d.sda = seq_q.tgt;
                end
                if (cnt_q == low_last) begin
                    seq_d.scl = 1'b0;
                    cnt_clr   = 1'b1;
                    unique case (seq_q.op)
                        OP_START: seq_d.ph = PH_SETUP;
                        OP_STOP:  seq_d.ph = PH_STOP_SU;
                        default:  seq_d.ph = PH_HIGH;
                    endcase
                end
            end
            PH_HIGH: begin
                if (cnt_q == half_last && seq_q.op == OP_READ) begin
                    seq_d.rd = sda_in;
                end
                if (cnt_q == high_last) begin
                    seq_d.scl = 1'b1;
                    seq_d.ph  = PH_IDLE;
                end
            end
            PH_SETUP: begin
                if (cnt_q == su_start_pt) begin
                    seq_d.sda = 1'b1;
                    seq_d.ph  = PH_HOLD;
                    cnt_clr   = 1'b1;
                end
            end
            PH_HOLD: begin
                if (cnt_q == hold_last) begin
                    seq_d.scl = 1'b1;
                    seq_d.ph  = PH_IDLE;
                end
            end
            PH_STOP_SU: begin
                if (cnt_q == su_stop_pt) begin
                    seq_d.sda = 1'b0;
                    seq_d.ph  = PH_IDLE;
                end
            end
            default: begin
                seq_d.ph = PH_IDLE;
                cnt_clr  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, op: OP_START, scl: 1'b0, sda: 1'b0,
                       tgt: 1'b0, rd: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign done     = (seq_q.ph == PH_IDLE);
    assign rd_bit   = seq_q.rd;
    assign scl_pull = seq_q.scl;
    assign sda_pull = seq_q.sda;

    // R3: SDA only moves while SCL is pulled, except at START/STOP edges
    p_sda_quiet_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_HIGH) |=> $stable(sda_pull));

    // R3: the update point always falls strictly inside the low phase
    p_update_before_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_LOW) |-> (upd_pt < low_last));

    // R5: during START hold, SCL is released and SDA is pulled
    p_start_hold_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_HOLD) |-> (!scl_pull && sda_pull));

    // R7: STOP setup keeps SCL released with SDA pulled
    p_stop_setup_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_STOP_SU) |-> (!scl_pull && sda_pull));

    // R9: requests while busy change neither the command nor the busy flag
    p_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && cmd_valid) |=> $stable(seq_q.op));

    // R10: data and STOP on a released bus leave it idle
    p_idle_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_valid && !scl_pull && cmd_op != 2'd0)
        |=> (done && !scl_pull && !sda_pull));

    // R8: rd_bit only moves during a READ
    p_rd_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.op != OP_READ) |=> $stable(rd_bit));

endmodule

// File: tb/i2c_bit_sequencer_bench.sv
module i2c_bit_sequencer_bench;
    localparam int DIV_W = 8;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic cmd_bit = 1'b0;
    logic [DIV_W-1:0] div_lo = '0, div_hi = '0;
    logic [CNT_W-1:0] start_cnt = '0, stop_cnt = '0;
    logic [2:0] upd_step = '0;
    logic ext_sda = 1'b1;
    logic sda_in, done, rd_bit, scl_pull, sda_pull;

    assign sda_in = ~sda_pull & ext_sda;

    i2c_bit_sequencer #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_i2c_bit_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bit(cmd_bit), .div_lo(div_lo), .div_hi(div_hi),
        .start_cnt(start_cnt), .stop_cnt(stop_cnt), .upd_step(upd_step),
        .sda_in(sda_in), .done(done), .rd_bit(rd_bit),
        .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    int l, h, u, p, s, cur_op;
    bit cur_bit, sda0, scl0, last_rd;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        summary();
    end

    task automatic set_cfg(input int dl, input int dh, input int sc, input int pc, input int st);
        div_lo = DIV_W'(dl); div_hi = DIV_W'(dh);
        start_cnt = CNT_W'(sc); stop_cnt = CNT_W'(pc); upd_step = 3'(st);
        l = dl + 1; h = dh + 1; u = sc + 1; p = pc + 1;
        s = ((st > 5) ? 5 : st) + 1;   // R4 clamp
    endtask

    function automatic int cmd_len();
        if (cur_op == 0) return scl0 ? 8*l + 8*h*u + 8*h*(u+1) : 8*h*u + 8*h*(u+1);
        if (cur_op == 3) return 8*l + 8*h*p + 1;
        return 8*l + 8*h;
    endfunction

    // expected {scl_pull, sda_pull, done} k cycles after acceptance
    function automatic logic [2:0] exp_at(input int k);
        int len, su;
        logic sc, sd;
        len = cmd_len();
        su = l*s + 1;
        if (cur_op == 0 && !scl0) begin
            sc = (k < len) ? 1'b0 : 1'b1;
            sd = (k < 8*h*u + 1) ? sda0 : 1'b1;
        end else if (cur_op == 0) begin
            sc = (k < 8*l) ? 1'b1 : ((k < len) ? 1'b0 : 1'b1);
            sd = (k < su) ? sda0 : ((k < 8*l + 8*h*u + 1) ? 1'b0 : 1'b1);
        end else if (cur_op == 3) begin
            sc = (k < 8*l) ? 1'b1 : 1'b0;
            sd = (k < su) ? sda0 : ((k < len) ? 1'b1 : 1'b0);
        end else begin
            sc = (k < 8*l) ? 1'b1 : ((k < len) ? 1'b0 : 1'b1);
            sd = (k < su) ? sda0 : ((cur_op == 1) ? ~cur_bit : 1'b0);
        end
        return {sc, sd, (k >= len) ? 1'b1 : 1'b0};
    endfunction

    task automatic run_cmd(input int op, input bit b, input bit ext);
        int len, kbad;
        bit bad;
        logic [2:0] got, ex, gbad, ebad;
        string tag;
        bad = 1'b0; kbad = 0; gbad = '0; ebad = '0;
        cur_op = op; cur_bit = b; sda0 = sda_pull; scl0 = scl_pull;
        ext_sda = (op == 2) ? ext : 1'b1;
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_bit = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        len = cmd_len();
        for (int k = 0; k <= len; k++) begin
            if (k > 0) @(negedge clk);
            got = {scl_pull, sda_pull, done};
            ex = exp_at(k);
            if (got !== ex && !bad) begin
                bad = 1'b1; kbad = k; gbad = got; ebad = ex;
            end
            if (k < len - 1 && ($urandom % 8) == 0) begin
                cmd_valid = 1'b1; cmd_op = 2'($urandom); cmd_bit = 1'($urandom);
            end else begin
                cmd_valid = 1'b0;
            end
        end
        cmd_valid = 1'b0;
        case (op)
            0: tag = scl0 ? "R6 repeated start" : "R5 start";
            1: tag = "R2/R3 write";
            2: tag = "R2/R3 read";
            default: tag = "R7 stop";
        endcase
        tag = $sformatf("%s R9%s at k=%0d", tag, (upd_step > 5) ? " R4" : "", kbad);
        check(!bad, tag, gbad, ebad);
        if (op == 2) begin
            check(rd_bit == ext, "R8 read capture", rd_bit, ext);
            last_rd = ext;
        end else if (op == 1) begin
            check(rd_bit == last_rd, "R8 rd_bit held", rd_bit, last_rd);
        end
        ext_sda = 1'b1;
    endtask

    task automatic ignore_check(input int op);
        bit ok;
        ok = 1'b1;
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_bit = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (!(done && !scl_pull && !sda_pull)) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, "R10 idle ignore", {scl_pull, sda_pull, done}, 3'b001);
    endtask

    task automatic run_seq(input int nbits);
        ignore_check(1 + ($urandom % 3));
        run_cmd(0, 1'b0, 1'b1);
        for (int i = 0; i < nbits; i++) begin
            if ($urandom % 2) run_cmd(1, 1'($urandom), 1'b1);
            else run_cmd(2, 1'b1, 1'($urandom));
            repeat ($urandom % 3) @(negedge clk);
        end
        if ($urandom % 2) begin
            run_cmd(0, 1'b0, 1'b1);
            run_cmd(1, 1'($urandom), 1'b1);
        end
        run_cmd(3, 1'b0, 1'b1);
    endtask

    initial begin
        void'($urandom(32'h1c2b));
        last_rd = 1'b0;
        set_cfg(0, 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_pull && !sda_pull && done, "R1 reset state",
              {scl_pull, sda_pull, done}, 3'b001);

        set_cfg(4, 2, 1, 1, 1);
        run_seq(3);
        set_cfg(0, 0, 0, 0, 7);     // R4 out-of-range step, minimum units
        run_seq(3);
        set_cfg(0, 0, 0, 0, 5);
        run_seq(2);
        set_cfg(3, 1, 2, 0, 0);
        run_seq(3);
        for (int r = 0; r < 20; r++) begin
            set_cfg($urandom % 4, $urandom % 4, $urandom % 3, $urandom % 3, $urandom % 8);
            run_seq(2 + $urandom % 4);
        end
        summary();
    end

endmodule